// File: doc/BRIEF.md
# Transaction ID Filtered Traffic Counter

This block watches the read and write address channels of a memory controller port and counts the transactions whose ID passes a programmable filter. A single 32-bit filter word is shared by every counter. Its low half is the ID to compare against. Its high half is a bit-select mask, held in inverted sense relative to what a user would ask for. Software flips that half before it writes the word.

Each counter slot has an 8-bit event code. A slot set to the filtered-read code follows the read address channel, a slot set to the filtered-write code follows the write address channel, and a slot holding any other code is left alone by this block. A mode input picks the counting unit. In burst mode each matching handshake adds one to the slot's burst total. In byte mode each matching handshake adds the number of bytes the burst moves to the slot's byte total. The two totals are read back through a combinational read port from two separate address windows.

Top module: `tid_filt_counter`

## Requirements
- R1: While reset is high, every burst total and every byte total is cleared to zero.
- R2: The filter word holds the ID in bits 15:0 and the stored mask in bits 31:16. A transaction ID (zero-extended to 16 bits) matches when, at every bit where the stored mask is 1, it equals the filter ID bit. Bits where the stored mask is 0 are not compared.
- R3: A slot with code 0x41 counts only read address handshakes (ar_valid and ar_ready both high in a cycle). A slot with code 0x42 counts only write address handshakes (aw_valid and aw_ready). A valid without ready, or a ready without valid, counts nothing.
- R4: A slot whose code is neither 0x41 nor 0x42 keeps both its totals unchanged whatever traffic and filter are applied.
- R5: With enh_mode low (burst mode), a matching handshake adds exactly one to the slot's burst total and leaves its byte total unchanged.
- R6: With enh_mode high (byte mode), a matching handshake adds (len + 1) << size to the slot's byte total and leaves its burst total unchanged.
- R7: A read and a write handshake in the same cycle each update the slots that follow their own channel, independently.
- R8: rd_data returns the burst total of slot n at rd_addr 0x20 + 4n and the byte total of slot n at rd_addr 0x30 + 4n, zero-extended to 32 bits. Any other address returns zero.
- R9: The counting unit is taken from enh_mode in the same cycle as the handshake, so a mode change applies from the next transaction onward.
- R10: Totals are CNT_W bits wide and wrap modulo 2^CNT_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| filt_cfg | input | 32 | Shared filter word: ID in 15:0, stored mask in 31:16 |
| enh_mode | input | 1 | 0 counts bursts, 1 counts bytes |
| evt_sel | input | NUM_CNT*8 | Event code of slot n in bits 8n+7:8n |
| ar_valid | input | 1 | Read address valid |
| ar_ready | input | 1 | Read address ready |
| ar_id | input | ID_W | Read transaction ID |
| ar_len | input | 8 | Read burst length minus one |
| ar_size | input | 3 | Read beat size, log2 of bytes |
| aw_valid | input | 1 | Write address valid |
| aw_ready | input | 1 | Write address ready |
| aw_id | input | ID_W | Write transaction ID |
| aw_len | input | 8 | Write burst length minus one |
| aw_size | input | 3 | Write beat size, log2 of bytes |
| rd_addr | input | 8 | Read-back byte address |
| rd_data | output | 32 | Read-back data |

## Verification
The assertions take the event codes and the mode as levels that matter only in the cycle of a handshake. They do not constrain traffic, but the single-step property for burst totals relies on each slot following only one channel. The bench changes the filter, codes and mode only at falling edges between handshakes. It sweeps every ID of a 4-bit ID space against several filter words on both channels at once. Read-back happens only while both valids are low, so the totals are stable while the port is scanned.

// File: rtl/tid_filt_pkg.sv
package tid_filt_pkg;

    localparam logic [7:0] EVT_FILT_RD = 8'h41;
    localparam logic [7:0] EVT_FILT_WR = 8'h42;

    localparam logic [7:0] BURST_WIN = 8'h20;
    localparam logic [7:0] BYTE_WIN  = 8'h30;

    localparam int FILT_W   = 16;
    localparam int BYTES_W  = 16;
    localparam int NUM_CH   = 2;
    localparam int CH_RD    = 0;
    localparam int CH_WR    = 1;

    typedef struct packed {
        logic [FILT_W-1:0] keep;
        logic [FILT_W-1:0] ref_id;
    } filt_cfg_t;

    typedef enum logic {
        UNIT_BURST = 1'b0,
        UNIT_BYTE  = 1'b1
    } cnt_unit_e;

    typedef struct packed {
        logic               hit;
        logic [BYTES_W-1:0] bytes;
    } qual_t;

    function automatic logic id_hit(logic [FILT_W-1:0] id, filt_cfg_t cfg);
        return ((id ^ cfg.ref_id) & cfg.keep) == '0;
    endfunction

    function automatic logic [BYTES_W-1:0] burst_bytes(logic [7:0] len, logic [2:0] size);
        logic [BYTES_W-1:0] beats;
        beats = BYTES_W'(len) + BYTES_W'(1);
        return beats << size;
    endfunction

endpackage

// File: rtl/tid_chan_qual.sv
module tid_chan_qual
    import tid_filt_pkg::*;
#(
    parameter int ID_W = 16
) (
    input  logic            valid,
    input  logic            ready,
    input  logic [ID_W-1:0] id,
    input  logic [7:0]      len,
    input  logic [2:0]      size,
    input  filt_cfg_t       cfg,
    output qual_t           q
);
    logic [FILT_W-1:0] id_ext;

    always_comb begin
        id_ext  = FILT_W'(id);
        q.hit   = valid && ready && id_hit(id_ext, cfg);
        q.bytes = burst_bytes(len, size);
    end
endmodule

// File: rtl/tid_cnt_slot.sv
module tid_cnt_slot
    import tid_filt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [7:0]       code,
    input  cnt_unit_e        unit,
    input  qual_t            rd_q,
    input  qual_t            wr_q,
    output logic [CNT_W-1:0] burst_q,
    output logic [CNT_W-1:0] byte_q
);
    logic               on_rd;
    logic               on_wr;
    logic               step;
    logic [BYTES_W-1:0] step_bytes;

    always_comb begin
        on_rd      = (code == EVT_FILT_RD);
        on_wr      = (code == EVT_FILT_WR);
        step       = (on_rd && rd_q.hit) || (on_wr && wr_q.hit);
        step_bytes = on_rd ? rd_q.bytes : wr_q.bytes;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            burst_q <= '0;
            byte_q  <= '0;
        end else if (step) begin
            if (unit == UNIT_BYTE) begin
                byte_q <= byte_q + CNT_W'(step_bytes);
            end else begin
                burst_q <= burst_q + CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/tid_rd_win.sv
module tid_rd_win
    import tid_filt_pkg::*;
#(
    parameter int NUM_CNT = 4,
    parameter int CNT_W   = 32
) (
    input  logic [7:0]                    rd_addr,
    input  logic [NUM_CNT-1:0][CNT_W-1:0] burst_q,
    input  logic [NUM_CNT-1:0][CNT_W-1:0] byte_q,
    output logic [31:0]                   rd_data
);
    always_comb begin
        rd_data = '0;
        for (int n = 0; n < NUM_CNT; n++) begin
            if (rd_addr == BURST_WIN + 8'(4 * n)) begin
                rd_data = 32'(burst_q[n]);
            end
            if (rd_addr == BYTE_WIN + 8'(4 * n)) begin
                rd_data = 32'(byte_q[n]);
            end
        end
    end
endmodule

// File: rtl/tid_filt_counter.sv
module tid_filt_counter
    import tid_filt_pkg::*;
#(
    parameter int NUM_CNT = 4,
    parameter int CNT_W   = 32,
    parameter int ID_W    = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [31:0]          filt_cfg,
    input  logic                 enh_mode,
    input  logic [NUM_CNT*8-1:0] evt_sel,
    input  logic                 ar_valid,
    input  logic                 ar_ready,
    input  logic [ID_W-1:0]      ar_id,
    input  logic [7:0]           ar_len,
    input  logic [2:0]           ar_size,
    input  logic                 aw_valid,
    input  logic                 aw_ready,
    input  logic [ID_W-1:0]      aw_id,
    input  logic [7:0]           aw_len,
    input  logic [2:0]           aw_size,
    input  logic [7:0]           rd_addr,
    output logic [31:0]          rd_data
);
    localparam int CODE_W = 8;

    filt_cfg_t cfg;
    cnt_unit_e unit;

    logic [NUM_CH-1:0]           ch_valid;
    logic [NUM_CH-1:0]           ch_ready;
    logic [NUM_CH-1:0][ID_W-1:0] ch_id;
    logic [NUM_CH-1:0][7:0]      ch_len;
    logic [NUM_CH-1:0][2:0]      ch_size;
    qual_t                       ch_q [NUM_CH];

    logic [NUM_CNT-1:0][CNT_W-1:0] burst_q;
    logic [NUM_CNT-1:0][CNT_W-1:0] byte_q;

    always_comb begin
        cfg  = filt_cfg_t'(filt_cfg);
        unit = cnt_unit_e'(enh_mode);

        ch_valid[CH_RD] = ar_valid;
        ch_ready[CH_RD] = ar_ready;
        ch_id[CH_RD]    = ar_id;
        ch_len[CH_RD]   = ar_len;
        ch_size[CH_RD]  = ar_size;

        ch_valid[CH_WR] = aw_valid;
        ch_ready[CH_WR] = aw_ready;
        ch_id[CH_WR]    = aw_id;
        ch_len[CH_WR]   = aw_len;
        ch_size[CH_WR]  = aw_size;
    end

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        tid_chan_qual #(
            .ID_W (ID_W)
        ) u_qual (
            .valid (ch_valid[ch]),
            .ready (ch_ready[ch]),
            .id    (ch_id[ch]),
            .len   (ch_len[ch]),
            .size  (ch_size[ch]),
            .cfg   (cfg),
            .q     (ch_q[ch])
        );
    end

    for (genvar n = 0; n < NUM_CNT; n++) begin : g_slot
        tid_cnt_slot #(
            .CNT_W (CNT_W)
        ) u_slot (
            .clk     (clk),
            .rst     (rst),
            .code    (evt_sel[n*CODE_W +: CODE_W]),
            .unit    (unit),
            .rd_q    (ch_q[CH_RD]),
            .wr_q    (ch_q[CH_WR]),
            .burst_q (burst_q[n]),
            .byte_q  (byte_q[n])
        );
    end

    tid_rd_win #(
        .NUM_CNT (NUM_CNT),
        .CNT_W   (CNT_W)
    ) u_win (
        .rd_addr (rd_addr),
        .burst_q (burst_q),
        .byte_q  (byte_q),
        .rd_data (rd_data)
    );
endmodule

// File: rtl/tid_filt_counter_chk.sv
module tid_filt_counter_chk
    import tid_filt_pkg::*;
#(
    parameter int NUM_CNT = 4,
    parameter int CNT_W   = 32
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          enh_mode,
    input logic [NUM_CNT*8-1:0]          evt_sel,
    input logic                          ar_valid,
    input logic                          ar_ready,
    input logic                          aw_valid,
    input logic                          aw_ready,
    input logic [7:0]                    rd_addr,
    input logic [31:0]                   rd_data,
    input logic [NUM_CNT-1:0][CNT_W-1:0] burst_q,
    input logic [NUM_CNT-1:0][CNT_W-1:0] byte_q
);
    logic unmapped;

    always_comb begin
        unmapped = 1'b1;
        for (int n = 0; n < NUM_CNT; n++) begin
            if (rd_addr == BURST_WIN + 8'(4 * n) || rd_addr == BYTE_WIN + 8'(4 * n)) begin
                unmapped = 1'b0;
            end
        end
    end

    // R8
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
        unmapped |-> rd_data == 32'd0);

    for (genvar n = 0; n < NUM_CNT; n++) begin : g_slot_chk
        // R1
        reset_clear_chk: assert property (@(posedge clk)
            rst |=> (burst_q[n] == '0 && byte_q[n] == '0));

        // R3
        idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (!(ar_valid && ar_ready) && !(aw_valid && aw_ready))
            |=> ($stable(burst_q[n]) && $stable(byte_q[n])));

        // R4
        foreign_code_chk: assert property (@(posedge clk) disable iff (rst)
            (evt_sel[n*8 +: 8] != EVT_FILT_RD && evt_sel[n*8 +: 8] != EVT_FILT_WR)
            |=> ($stable(burst_q[n]) && $stable(byte_q[n])));

        // R5
        burst_bytes_hold_chk: assert property (@(posedge clk) disable iff (rst)
            !enh_mode |=> $stable(byte_q[n]));

        // R5
        burst_single_step_chk: assert property (@(posedge clk) disable iff (rst)
            !enh_mode |=> CNT_W'(burst_q[n] - $past(burst_q[n])) <= CNT_W'(1));

        // R6
        byte_burst_hold_chk: assert property (@(posedge clk) disable iff (rst)
            enh_mode |=> $stable(burst_q[n]));
    end
endmodule

bind tid_filt_counter tid_filt_counter_chk #(
    .NUM_CNT (NUM_CNT),
    .CNT_W   (CNT_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .enh_mode (enh_mode),
    .evt_sel  (evt_sel),
    .ar_valid (ar_valid),
    .ar_ready (ar_ready),
    .aw_valid (aw_valid),
    .aw_ready (aw_ready),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .burst_q  (burst_q),
    .byte_q   (byte_q)
);

// File: tb/tid_filt_counter_tb.sv
module tid_filt_counter_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NUM_CNT    = 4;
    localparam int CNT_W      = 16;
    localparam int ID_W       = 4;
    localparam longint MODV   = 64'd1 << CNT_W;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic [31:0]          filt_cfg = '0;
    logic                 enh_mode = 1'b0;
    logic [NUM_CNT*8-1:0] evt_sel = '0;
    logic                 ar_valid = 1'b0, ar_ready = 1'b0;
    logic [ID_W-1:0]      ar_id = '0;
    logic [7:0]           ar_len = '0;
    logic [2:0]           ar_size = '0;
    logic                 aw_valid = 1'b0, aw_ready = 1'b0;
    logic [ID_W-1:0]      aw_id = '0;
    logic [7:0]           aw_len = '0;
    logic [2:0]           aw_size = '0;
    logic [7:0]           rd_addr = '0;
    logic [31:0]          rd_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [7:0]  codes [NUM_CNT];
    longint      exp_burst [NUM_CNT];
    longint      exp_byte [NUM_CNT];

    always #(CLK_PERIOD/2) clk = ~clk;

    tid_filt_counter #(
        .NUM_CNT (NUM_CNT),
        .CNT_W   (CNT_W),
        .ID_W    (ID_W)
    ) u_dut (
        .clk (clk), .rst (rst), .filt_cfg (filt_cfg), .enh_mode (enh_mode),
        .evt_sel (evt_sel),
        .ar_valid (ar_valid), .ar_ready (ar_ready), .ar_id (ar_id),
        .ar_len (ar_len), .ar_size (ar_size),
        .aw_valid (aw_valid), .aw_ready (aw_ready), .aw_id (aw_id),
        .aw_len (aw_len), .aw_size (aw_size),
        .rd_addr (rd_addr), .rd_data (rd_data)
    );

    function automatic bit m_match(int unsigned id, logic [31:0] cfg);
        for (int b = 0; b < 16; b++) begin
            if (cfg[16+b] && (((id >> b) & 1) != int'(cfg[b]))) return 1'b0;
        end
        return 1'b1;
    endfunction

    task automatic m_add(int n, int unsigned len, int unsigned size, bit mode);
        if (mode) exp_byte[n] = (exp_byte[n] + longint'(len + 1) * (longint'(1) << size)) % MODV;
        else      exp_burst[n] = (exp_burst[n] + 1) % MODV;
    endtask

    task automatic set_codes(logic [7:0] c0, logic [7:0] c1, logic [7:0] c2, logic [7:0] c3);
        @(negedge clk);
        codes[0] = c0; codes[1] = c1; codes[2] = c2; codes[3] = c3;
        evt_sel = {c3, c2, c1, c0};
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        ar_valid = 0; aw_valid = 0;
        @(negedge clk);
        rst = 1'b0;
        for (int n = 0; n < NUM_CNT; n++) begin
            exp_burst[n] = 0;
            exp_byte[n]  = 0;
        end
    endtask

    task automatic txn(bit rv, bit rr, int unsigned rid, int unsigned rlen, int unsigned rsz,
                       bit wv, bit wr, int unsigned wid, int unsigned wlen, int unsigned wsz,
                       bit mode);
        @(negedge clk);
        ar_valid = rv; ar_ready = rr; ar_id = ID_W'(rid); ar_len = 8'(rlen); ar_size = 3'(rsz);
        aw_valid = wv; aw_ready = wr; aw_id = ID_W'(wid); aw_len = 8'(wlen); aw_size = 3'(wsz);
        enh_mode = mode;
        for (int n = 0; n < NUM_CNT; n++) begin
            if (codes[n] == 8'h41 && rv && rr && m_match(rid, filt_cfg)) m_add(n, rlen, rsz, mode);
            if (codes[n] == 8'h42 && wv && wr && m_match(wid, filt_cfg)) m_add(n, wlen, wsz, mode);
        end
    endtask

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
        end
    endtask

    task automatic readback(string tag);
        @(negedge clk);
        ar_valid = 0; aw_valid = 0; ar_ready = 0; aw_ready = 0;
        for (int n = 0; n < NUM_CNT; n++) begin
            @(negedge clk);
            rd_addr = 8'h20 + 8'(4 * n);
            #1;
            check($sformatf("%s R8 burst total slot %0d", tag, n), rd_data, 32'(exp_burst[n]));
            @(negedge clk);
            rd_addr = 8'h30 + 8'(4 * n);
            #1;
            check($sformatf("%s R8 byte total slot %0d", tag, n), rd_data, 32'(exp_byte[n]));
        end
        @(negedge clk);
        rd_addr = 8'h00;
        #1;
        check({tag, " R8 unmapped 0x00"}, rd_data, 32'd0);
        @(negedge clk);
        rd_addr = 8'h24 + 8'h1;
        #1;
        check({tag, " R8 unmapped 0x25"}, rd_data, 32'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] cfgs [4];
        cfgs[0] = 32'hFFFF_0005;
        cfgs[1] = 32'h000C_0008;
        cfgs[2] = 32'h0000_0000;
        cfgs[3] = 32'h0001_0001;

        set_codes(8'h41, 8'h42, 8'h41, 8'h05);
        do_reset();
        // R1: all totals zero after reset
        readback("R1");

        // R2/R3/R5/R7: burst mode sweep over every ID on both channels at once
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            filt_cfg = cfgs[c];
            for (int id = 0; id < 16; id++) begin
                txn(1, 1, id, id, id % 4, 1, 1, 15 - id, 15 - id, (id + 1) % 4, 0);
            end
            readback($sformatf("R2/R3/R5/R7 cfg%0d", c));
        end

        // R2/R6: byte mode sweep
        do_reset();
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            filt_cfg = cfgs[c];
            for (int id = 0; id < 16; id++) begin
                txn(1, 1, id, id * 3, id % 8, 1, 1, id ^ 5, id + 1, 7 - (id % 8), 1);
            end
            readback($sformatf("R2/R6 cfg%0d", c));
        end

        // R9: mode alternating per transaction
        do_reset();
        @(negedge clk);
        filt_cfg = 32'h0000_0000;
        for (int k = 0; k < 12; k++) begin
            txn(1, 1, k, k, 2, k % 3 == 0, 1, k, 1, 1, k % 2);
        end
        readback("R9");

        // R3: valid without ready and ready without valid count nothing
        do_reset();
        for (int k = 0; k < 8; k++) begin
            txn(1, 0, k, 3, 1, 0, 1, k, 3, 1, k % 2);
        end
        readback("R3 no handshake");

        // R4: non-filtered codes including neighbours of the filtered codes
        set_codes(8'h42, 8'h40, 8'h00, 8'h43);
        do_reset();
        for (int k = 0; k < 10; k++) begin
            txn(1, 1, k, k, 1, 1, 1, k, 2, 0, k % 2);
        end
        readback("R4");

        // R7: simultaneous read and write, both slots following their own channel
        set_codes(8'h41, 8'h42, 8'h42, 8'h41);
        do_reset();
        @(negedge clk);
        filt_cfg = 32'hFFFF_0003;
        txn(1, 1, 3, 0, 0, 1, 1, 3, 0, 0, 0);
        txn(1, 1, 3, 0, 0, 1, 1, 2, 0, 0, 0);
        txn(1, 1, 1, 1, 2, 1, 1, 3, 3, 2, 1);
        readback("R7");

        // R10: byte total wraps at 2^CNT_W
        do_reset();
        @(negedge clk);
        filt_cfg = 32'h0000_0000;
        for (int k = 0; k < 3; k++) begin
            txn(1, 1, 0, 255, 7, 1, 1, 0, 255, 7, 1);
        end
        readback("R10 byte wrap");
        // R10: burst total wraps too after (2^CNT_W)+2 bursts
        for (int k = 0; k < 65538; k++) begin
            txn(1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        end
        readback("R10 burst wrap");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule